// File: doc/BRIEF.md
# Power-Mode-Aware Clock Enable Bank

This block owns one clock enable for each of a large set of on-chip clients. Software gives every enable a 2-bit policy. The policy says whether that client's clock keeps running in normal operation, in the light sleep state and in the deep sleep state. The policies sit in a bank of 32-bit registers. Each register holds sixteen policies, so the default build controls 128 enables.

A separate 2-bit mode register chooses the low-power state the system enters when a sleep request arrives. The choices are to stay in run, to drop to wait, or to drop to stop. A wake input always brings the system back to run. Each client's raw enable passes through only when its policy allows the current power state. The result is delivered one clock edge later as a registered gated enable.

Top module: `clk_gate_bank`

## Requirements
- R1: During reset the gated enables are all 0. Reset loads every policy field with 11, loads the mode register with 00 and puts the power state in run. On the first edge after reset, every gated enable therefore equals its raw enable.
- R2: Addresses 0 to 7 select the policy registers. Field n of register r is bits [2n+1:2n] and controls gate 16*r+n. Address 8 is the mode register: bits [1:0] can be written and the upper bits read as 0. Writes to addresses 9 to 15 are ignored, and reads there return 0. Reads are combinational.
- R3: Policy 00 keeps the gate off in run, wait and stop.
- R4: Policy 01 lets the raw enable through in run only.
- R5: Policy 11 lets the raw enable through in run and wait. In stop every gated enable is 0.
- R6: Policy 10 is reserved and keeps the gate off in every power state.
- R7: When the power state is run and the sleep request is high, the next edge moves the power state (curMode: 00 run, 01 wait, 10 stop) to the state the mode register selects. A mode value of 00 or 11 keeps it in run.
- R8: A wake request returns the power state to run on the next edge, even if a sleep request arrives in the same cycle. In wait or stop, a sleep request alone leaves the power state unchanged.
- R9: Each gated enable is registered. It reflects the raw enable, the policy and the power state as they stood before the previous edge. A change to any of these inputs therefore shows one edge later.
- R10: Rewriting one register with a single field changed, after reading it back, alters only that field and its gate. Every other field and register is left as it was.
- R11: curMode never shows the value 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Write strobe for the register port |
| regAddr | input | 4 | Register address (0-7 policies, 8 mode) |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data for regAddr |
| sleepReq | input | 1 | Sleep request, acted on in run only |
| wakeReq | input | 1 | Wake request, returns to run |
| rawEn | input | 128 | Unconditioned clock enables, one per gate |
| gatedEn | output | 128 | Registered, policy-filtered enables |
| curMode | output | 2 | Present power state: 00 run, 01 wait, 10 stop |

## Verification
Register writes land on the edge that follows the strobe, and reads are combinational, so the bench reads back one falling edge after each write. A sleep or wake request changes curMode on the next edge. The gated enables follow one edge after that, so the bench checks curMode on the first falling edge and the gated vector on the second. Right after changing rawEn, and again on the edge where the power state leaves stop, the bench checks that the gated vector still holds its old value. This confirms the single register stage. All four policy codes are swept across every register and all three power states, with several raw-enable patterns, against a model of the policy rules computed in the bench.

// File: rtl/gate_pkg.sv
package gate_pkg;

  typedef enum logic [1:0] {
    PWR_RUN  = 2'b00,
    PWR_WAIT = 2'b01,
    PWR_STOP = 2'b10
  } pwr_e;

  // strobes from control to datapath
  typedef struct packed {
    logic gateWr;
    logic gateSel;
    logic modeSel;
    pwr_e pwrState;
  } gateStrobe_t;

  // policy decode: does a gate with this code run in this power state
  function automatic logic gateAllow(input logic [1:0] code, input pwr_e st);
    case (code)
      2'b01:   return st == PWR_RUN;
      2'b11:   return st != PWR_STOP;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/gate_ctrl.sv
module gate_ctrl
  import gate_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int ADDR_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [1:0]        modeWrData,
  input  logic              sleepReq,
  input  logic              wakeReq,
  output gateStrobe_t       strobe,
  output logic [1:0]        sleepMode
);

  localparam logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(NUM_REGS);

  logic isGate;
  logic isMode;
  pwr_e pwrQ;
  pwr_e pwrD;

  assign isGate = regAddr < MODE_ADDR;
  assign isMode = regAddr == MODE_ADDR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sleepMode <= 2'b00;
    end else if (regWrEn && isMode) begin
      sleepMode <= modeWrData;
    end
  end

  // wake wins; sleep is acted on only from run
  always_comb begin
    pwrD = pwrQ;
    if (wakeReq) begin
      pwrD = PWR_RUN;
    end else if (pwrQ == PWR_RUN && sleepReq) begin
      case (sleepMode)
        2'b01:   pwrD = PWR_WAIT;
        2'b10:   pwrD = PWR_STOP;
        default: pwrD = PWR_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) pwrQ <= PWR_RUN;
    else       pwrQ <= pwrD;
  end

  always_comb begin
    strobe.gateWr   = regWrEn && isGate;
    strobe.gateSel  = isGate;
    strobe.modeSel  = isMode;
    strobe.pwrState = pwrQ;
  end

endmodule

// File: rtl/gate_datapath.sv
module gate_datapath
  import gate_pkg::*;
#(
  parameter int NUM_REGS  = 8,
  parameter int FIELDS    = 16,
  parameter int REG_W     = 2 * FIELDS,
  parameter int NUM_GATES = NUM_REGS * FIELDS,
  parameter int IDX_W     = $clog2(NUM_REGS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  gateStrobe_t          strobe,
  input  logic [IDX_W-1:0]     regIdx,
  input  logic [REG_W-1:0]     wrData,
  input  logic [NUM_GATES-1:0] rawEn,
  output logic [REG_W-1:0]     rdGate,
  output logic [NUM_GATES-1:0] gatedEn
);

  logic [REG_W-1:0]     bankQ [NUM_REGS];
  logic [NUM_GATES-1:0] allowVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < NUM_REGS; r++) bankQ[r] <= '1;
    end else if (strobe.gateWr) begin
      bankQ[regIdx] <= wrData;
    end
  end

  assign rdGate = strobe.gateSel ? bankQ[regIdx] : '0;

  for (genvar g = 0; g < NUM_GATES; g++) begin : g_gate
    localparam int REG_I = g / FIELDS;
    localparam int FLD_I = g % FIELDS;
    assign allowVec[g] = gateAllow(bankQ[REG_I][2*FLD_I +: 2], strobe.pwrState);
  end

  always_ff @(posedge clk) begin
    if (!rstN) gatedEn <= '0;
    else       gatedEn <= rawEn & allowVec;
  end

endmodule

// File: rtl/clk_gate_bank.sv
module clk_gate_bank
  import gate_pkg::*;
#(
  parameter  int NUM_REGS  = 8,
  parameter  int FIELDS    = 16,
  localparam int REG_W     = 2 * FIELDS,
  localparam int NUM_GATES = NUM_REGS * FIELDS,
  localparam int ADDR_W    = $clog2(NUM_REGS + 1),
  localparam int IDX_W     = $clog2(NUM_REGS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [REG_W-1:0]     regWrData,
  output logic [REG_W-1:0]     regRdData,
  input  logic                 sleepReq,
  input  logic                 wakeReq,
  input  logic [NUM_GATES-1:0] rawEn,
  output logic [NUM_GATES-1:0] gatedEn,
  output logic [1:0]           curMode
);

  gateStrobe_t      strobe;
  logic [1:0]       sleepMode;
  logic [REG_W-1:0] rdGate;

  gate_ctrl #(
    .NUM_REGS(NUM_REGS),
    .ADDR_W  (ADDR_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .modeWrData(regWrData[1:0]),
    .sleepReq  (sleepReq),
    .wakeReq   (wakeReq),
    .strobe    (strobe),
    .sleepMode (sleepMode)
  );

  gate_datapath #(
    .NUM_REGS (NUM_REGS),
    .FIELDS   (FIELDS),
    .REG_W    (REG_W),
    .NUM_GATES(NUM_GATES),
    .IDX_W    (IDX_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .regIdx (regAddr[IDX_W-1:0]),
    .wrData (regWrData),
    .rawEn  (rawEn),
    .rdGate (rdGate),
    .gatedEn(gatedEn)
  );

  assign regRdData = strobe.modeSel ? {{(REG_W-2){1'b0}}, sleepMode} : rdGate;
  assign curMode   = strobe.pwrState;

endmodule

// File: rtl/clk_gate_bank_chk.sv
module clk_gate_bank_chk #(
  parameter int NUM_GATES = 128
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 sleepReq,
  input logic                 wakeReq,
  input logic [NUM_GATES-1:0] rawEn,
  input logic [NUM_GATES-1:0] gatedEn,
  input logic [1:0]           curMode
);

  // R8
  wake_to_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |=> curMode == 2'b00);

  // R8
  sleep_outside_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    (curMode != 2'b00 && !wakeReq) |=> curMode == $past(curMode));

  // R7
  run_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == 2'b00 && !sleepReq) |=> curMode == 2'b00);

  // R5
  stop_gates_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    curMode == 2'b10 |=> gatedEn == '0);

  // R9
  gate_subset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (gatedEn & ~$past(rawEn)) == '0);

  // R11
  mode_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    curMode != 2'b11);

endmodule

bind clk_gate_bank clk_gate_bank_chk #(.NUM_GATES(NUM_GATES)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .sleepReq(sleepReq),
  .wakeReq (wakeReq),
  .rawEn   (rawEn),
  .gatedEn (gatedEn),
  .curMode (curMode)
);

// File: tb/clk_gate_bank_tb.sv
`timescale 1ns/1ps
module clk_gate_bank_tb;

  localparam int NR = 8;
  localparam int NF = 16;
  localparam int NG = NR * NF;

  logic          clk = 1'b0;
  logic          rstN;
  logic          regWrEn;
  logic [3:0]    regAddr;
  logic [31:0]   regWrData;
  logic [31:0]   regRdData;
  logic          sleepReq;
  logic          wakeReq;
  logic [NG-1:0] rawEn;
  logic [NG-1:0] gatedEn;
  logic [1:0]    curMode;

  int errors = 0;
  int checks = 0;
  logic [31:0] mdl [NR];

  always #2 clk = ~clk;

  clk_gate_bank u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .sleepReq(sleepReq),
    .wakeReq(wakeReq), .rawEn(rawEn), .gatedEn(gatedEn), .curMode(curMode)
  );

  task automatic chk(input string req, input logic [NG-1:0] act, input logic [NG-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrReg(input int a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = 4'(a); regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input int a, output logic [31:0] v);
    regAddr = 4'(a);
    #1;
    v = regRdData;
  endtask

  task automatic pulseSleep();
    sleepReq = 1'b1;
    @(negedge clk);
    sleepReq = 1'b0;
  endtask

  task automatic pulseWake();
    wakeReq = 1'b1;
    @(negedge clk);
    wakeReq = 1'b0;
  endtask

  // policy rules from R3..R6, state codes from R7
  function automatic logic [NG-1:0] expGate(input logic [NG-1:0] raw, input logic [1:0] st);
    logic [NG-1:0] e;
    for (int g = 0; g < NG; g++) begin
      logic [1:0] c;
      logic ok;
      c = mdl[g / NF][2*(g % NF) +: 2];
      ok = (c == 2'b01) ? (st == 2'b00) : (c == 2'b11) ? (st != 2'b10) : 1'b0;
      e[g] = raw[g] & ok;
    end
    return e;
  endfunction

  function automatic logic [NG-1:0] rawPat(input int p);
    case (p)
      0:       return {4{32'hFFFF_FFFF}};
      1:       return {4{32'hA5A5_5A5A}};
      default: return {32'h1357_9BDF, 32'h2468_ACE0, 32'hFEDC_BA98, 32'h0F1E_2D3C};
    endcase
  endfunction

  task automatic readAll(input string req);
    logic [31:0] v;
    for (int r = 0; r < NR; r++) begin
      rdReg(r, v);
      chk(req, NG'(v), NG'(mdl[r]));
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finishRun();
  end

  initial begin
    logic [31:0] v;
    logic [NG-1:0] prev;
    rstN = 1'b0; regWrEn = 1'b0; regAddr = '0; regWrData = '0;
    sleepReq = 1'b0; wakeReq = 1'b0; rawEn = rawPat(2);
    for (int r = 0; r < NR; r++) mdl[r] = '1;
    repeat (3) @(negedge clk);
    chk("R1 gated low in reset", gatedEn, '0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 all policies 11 after reset", gatedEn, rawEn);
    chk("R1 run after reset", NG'(curMode), '0);
    readAll("R1 R2 reset policy value");
    rdReg(8, v);
    chk("R1 mode reg reset", NG'(v), '0);

    // every register holds all four codes, rotated per register
    for (int r = 0; r < NR; r++) begin
      logic [31:0] d;
      for (int n = 0; n < NF; n++) d[2*n +: 2] = 2'((n + r) % 4);
      wrReg(r, d);
      mdl[r] = d;
    end
    readAll("R2 pattern readback");
    @(negedge clk);

    for (int p = 0; p < 3; p++) begin
      prev = gatedEn;
      rawEn = rawPat(p);
      #1;
      chk("R9 no same-cycle change", gatedEn, prev);
      @(negedge clk);
      chk("R3 R4 R6 run policies", gatedEn, expGate(rawEn, 2'b00));
    end

    for (int m = 1; m <= 2; m++) begin
      wrReg(8, 32'(m));
      pulseSleep();
      chk("R7 enter low-power state", NG'(curMode), NG'(m));
      @(negedge clk);
      for (int p = 0; p < 3; p++) begin
        rawEn = rawPat(p);
        @(negedge clk);
        chk("R3 R4 R5 R6 low-power policies", gatedEn, expGate(rawEn, 2'(m)));
      end
      pulseWake();
      chk("R8 wake to run", NG'(curMode), '0);
      chk("R9 gates lag wake by one edge", gatedEn, expGate(rawEn, 2'(m)));
      @(negedge clk);
      chk("R9 gates after wake", gatedEn, expGate(rawEn, 2'b00));
    end

    wrReg(8, 32'h0);
    pulseSleep();
    chk("R7 mode 00 stays in run", NG'(curMode), '0);
    wrReg(8, 32'hFFFF_FFFF);
    rdReg(8, v);
    chk("R2 mode upper bits read zero", NG'(v), NG'(3));
    pulseSleep();
    chk("R7 mode 11 stays in run", NG'(curMode), '0);

    wrReg(8, 32'h1);
    pulseSleep();
    chk("R7 enter wait", NG'(curMode), NG'(1));
    wrReg(8, 32'h2);
    sleepReq = 1'b1;
    repeat (2) @(negedge clk);
    sleepReq = 1'b0;
    chk("R8 sleep ignored in wait", NG'(curMode), NG'(1));
    wakeReq = 1'b1; sleepReq = 1'b1;
    @(negedge clk);
    wakeReq = 1'b0; sleepReq = 1'b0;
    chk("R8 wake beats sleep", NG'(curMode), '0);
    @(negedge clk);
    chk("R8 run held after wake", NG'(curMode), '0);

    // R10 single-field read-modify-write of gate 53
    rdReg(3, v);
    v[11:10] = 2'b00;
    wrReg(3, v);
    mdl[3] = v;
    readAll("R10 other fields untouched");
    @(negedge clk);
    chk("R10 gates after field rewrite", gatedEn, expGate(rawEn, 2'b00));

    for (int a = 9; a < 16; a++) begin
      wrReg(a, 32'h0);
      rdReg(a, v);
      chk("R2 unmapped read zero", NG'(v), '0);
    end
    readAll("R2 unmapped writes ignored");
    rdReg(8, v);
    chk("R2 mode reg kept", NG'(v), NG'(2));

    finishRun();
  end

endmodule